// File: doc/BRIEF.md
# Mode-Switched Memory Map Decoder

This block is the address-decoding core of an adapter that sits in a cartridge slot. For every word-aligned access it says where each 16-bit half of the returned word comes from: BIOS flash, the expansion port, the pass-through cartridge, DRAM, the code flash, the I/O page, or open bus. Because the two halves are selected separately, one word can be assembled from two sources. Memory contents are not part of the block. Its outputs are the selects, a DRAM offset with write enable, and the word an open-bus read returns.

The map depends on a mode number held in a small control page. That page must first be unlocked by writing a key to an enable register. DRAM writes are limited to the first 32 MB of the array and are refused in the read-only modes. DRAM windows wider than the array wrap around it.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the mode register is 0 and the register enable is clear. Mode 0 decodes as described in R4.
- R2: A write to address 0xB78x_xx0C sets the register enable when bits [7:0] of the written data equal 0x0A, whatever the upper bits are. Any other low byte clears it. The change is visible on the cycle after the write.
- R3: A write to address 0xB78x_xx00 loads data bits [2:0] into the mode register only while the enable is set. Otherwise the mode is unchanged.
- R4: Source codes are BIOS=0, EXP=1, CART=2, DRAM=3, CFLASH=4, IO=5, OPEN=6. In modes 0 and 1 the top address byte maps as follows: 0xB0 BIOS, 0xB1 EXP, 0xB2 CART, 0xB3 to 0xB5 DRAM (writable), 0xB6 BIOS, 0xB7 CFLASH. Both halves use the same source.
- R5: In modes 2 and 3: 0xB0 EXP, 0xB1 CART, 0xB2 to 0xB5 DRAM (writable). 0xB6 is split, with the high half from EXP and the low half from BIOS. 0xB7 is split, with the high half from EXP and the low half from CFLASH.
- R6: In mode 4: 0xB0 to 0xB3 DRAM (read-only, window based at 0xB0), 0xB4 EXP, 0xB5 CART, and 0xB6/0xB7 split as in R5.
- R7: In modes 5 to 7: 0xB0 to 0xB5 DRAM (read-only, window based at 0xB0), 0xB6 BIOS, 0xB7 CFLASH.
- R8: Addresses 0xB78x_xxxx select IO in both halves in every mode. Top bytes outside 0xB0 to 0xB7 select OPEN in both halves.
- R9: A BIOS, CART or CFLASH half whose offset (address bits [23:0]) is at or beyond that source's size (defaults 0x40000, 0xC00000, 0x40000) selects OPEN instead.
- R10: open_data always equals the low halfword of the address repeated in both halves.
- R11: dram_addr is the offset from the start of the DRAM window, taken modulo 32 MB. Each top byte spans 16 MB.
- R12: dram_we is high only for a valid write where both halves select DRAM, in a writable mode, and where the window offset is below 32 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Word-aligned access address |
| acc_wdata | input | 32 | Write data |
| sel_hi | output | 3 | Source of bits [31:16] |
| sel_lo | output | 3 | Source of bits [15:0] |
| dram_addr | output | 25 | Mirrored DRAM byte offset |
| dram_we | output | 1 | DRAM write allowed |
| open_data | output | 32 | Open-bus return word |
| mode_q | output | 3 | Current mode |
| regs_en_q | output | 1 | Control registers unlocked |

## Verification
The hardest situation to reach from the ports is a DRAM access that lands in the part of a window lying past 32 MB. The address wraps onto the array for reads, but the write must still be refused. To get there, the stimulus first unlocks the control page and moves into a mode whose window starts low enough that its top bytes reach past the array. It then issues a write at 0xB5 in mode 0 and compares it with a write at 0xB3. A second hard case is the lock itself: mode writes are sent before the unlock, after a wrong key and after re-unlocking, and the mode is read back each time.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    SRC_BIOS   = 3'd0,
    SRC_EXP    = 3'd1,
    SRC_CART   = 3'd2,
    SRC_DRAM   = 3'd3,
    SRC_CFLASH = 3'd4,
    SRC_IO     = 3'd5,
    SRC_OPEN   = 3'd6
  } src_e;

  typedef enum logic [1:0] {
    MAP_STD,
    MAP_SPLIT,
    MAP_RO4,
    MAP_MIRROR
  } map_e;

  // Mode number to map family.
  function automatic map_e f_map_class(logic [MODE_W-1:0] m);
    case (m)
      3'd0, 3'd1: return MAP_STD;
      3'd2, 3'd3: return MAP_SPLIT;
      3'd4:       return MAP_RO4;
      default:    return MAP_MIRROR;
    endcase
  endfunction

  // Word returned when nothing drives the bus.
  function automatic logic [31:0] f_open_word(logic [31:0] a);
    return {a[15:0], a[15:0]};
  endfunction

  // Byte offset into a DRAM window that starts at top byte 'base'.
  function automatic logic [26:0] f_dram_span(logic [7:0] top, logic [7:0] base,
                                              logic [23:0] off);
    logic [7:0] d;
    d = top - base;
    return {d[2:0], off};
  endfunction

endpackage

// File: rtl/mmd_ctrl_regs.sv
module mmd_ctrl_regs
  import mmd_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr_hit,
  input  logic              mode_wr_hit,
  input  logic [7:0]        wbyte,
  output logic              regs_en_q,
  output logic [MODE_W-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_en_q <= 1'b0;
      mode_q    <= '0;
    end else begin
      if (en_wr_hit)
        regs_en_q <= (wbyte == UNLOCK_KEY);
      if (mode_wr_hit && regs_en_q)
        mode_q <= wbyte[MODE_W-1:0];
    end
  end

endmodule

// File: rtl/mmd_region_decode.sv
module mmd_region_decode
  import mmd_pkg::*;
#(
  parameter int unsigned BIOS_BYTES   = 32'h0004_0000,
  parameter int unsigned CART_BYTES   = 32'h00C0_0000,
  parameter int unsigned CFLASH_BYTES = 32'h0004_0000,
  parameter logic [3:0]  IO_NIBBLE    = 4'h8
) (
  input  logic [31:0]       addr,
  input  logic [MODE_W-1:0] mode,
  output src_e              hi_src,
  output src_e              lo_src,
  output logic [7:0]        dram_base,
  output logic              dram_rw
);

  logic [7:0]  top;
  logic [23:0] off;
  map_e        cls;
  src_e        hi_raw, lo_raw;

  assign top = addr[31:24];
  assign off = addr[23:0];
  assign cls = f_map_class(mode);

  function automatic src_e f_limit(src_e s, logic [23:0] o);
    logic [31:0] wo;
    wo = {8'd0, o};
    case (s)
      SRC_BIOS:   return (wo < BIOS_BYTES)   ? s : SRC_OPEN;
      SRC_CART:   return (wo < CART_BYTES)   ? s : SRC_OPEN;
      SRC_CFLASH: return (wo < CFLASH_BYTES) ? s : SRC_OPEN;
      default:    return s;
    endcase
  endfunction

  always_comb begin
    hi_raw    = SRC_OPEN;
    lo_raw    = SRC_OPEN;
    dram_base = 8'hB0;
    dram_rw   = 1'b0;
    case (cls)
      MAP_STD: begin
        case (top)
          8'hB0, 8'hB6: begin hi_raw = SRC_BIOS; lo_raw = SRC_BIOS; end
          8'hB1:        begin hi_raw = SRC_EXP;  lo_raw = SRC_EXP;  end
          8'hB2:        begin hi_raw = SRC_CART; lo_raw = SRC_CART; end
          8'hB3, 8'hB4, 8'hB5: begin
            hi_raw = SRC_DRAM; lo_raw = SRC_DRAM;
            dram_base = 8'hB3; dram_rw = 1'b1;
          end
          8'hB7:        begin hi_raw = SRC_CFLASH; lo_raw = SRC_CFLASH; end
          default: ;
        endcase
      end
      MAP_SPLIT: begin
        case (top)
          8'hB0: begin hi_raw = SRC_EXP;  lo_raw = SRC_EXP;  end
          8'hB1: begin hi_raw = SRC_CART; lo_raw = SRC_CART; end
          8'hB2, 8'hB3, 8'hB4, 8'hB5: begin
            hi_raw = SRC_DRAM; lo_raw = SRC_DRAM;
            dram_base = 8'hB2; dram_rw = 1'b1;
          end
          8'hB6: begin hi_raw = SRC_EXP; lo_raw = SRC_BIOS;   end
          8'hB7: begin hi_raw = SRC_EXP; lo_raw = SRC_CFLASH; end
          default: ;
        endcase
      end
      MAP_RO4: begin
        case (top)
          8'hB0, 8'hB1, 8'hB2, 8'hB3: begin
            hi_raw = SRC_DRAM; lo_raw = SRC_DRAM; dram_base = 8'hB0;
          end
          8'hB4: begin hi_raw = SRC_EXP;  lo_raw = SRC_EXP;    end
          8'hB5: begin hi_raw = SRC_CART; lo_raw = SRC_CART;   end
          8'hB6: begin hi_raw = SRC_EXP;  lo_raw = SRC_BIOS;   end
          8'hB7: begin hi_raw = SRC_EXP;  lo_raw = SRC_CFLASH; end
          default: ;
        endcase
      end
      default: begin
        case (top)
          8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5: begin
            hi_raw = SRC_DRAM; lo_raw = SRC_DRAM; dram_base = 8'hB0;
          end
          8'hB6: begin hi_raw = SRC_BIOS;   lo_raw = SRC_BIOS;   end
          8'hB7: begin hi_raw = SRC_CFLASH; lo_raw = SRC_CFLASH; end
          default: ;
        endcase
      end
    endcase
    if (top == 8'hB7 && addr[23:20] == IO_NIBBLE) begin
      hi_raw = SRC_IO;
      lo_raw = SRC_IO;
    end
  end

  assign hi_src = f_limit(hi_raw, off);
  assign lo_src = f_limit(lo_raw, off);

endmodule

// File: rtl/mmd_dram_gate.sv
module mmd_dram_gate
  import mmd_pkg::*;
#(
  parameter int DRAM_AW = 25
) (
  input  logic [31:0]        addr,
  input  logic               wr_req,
  input  src_e               hi_src,
  input  src_e               lo_src,
  input  logic [7:0]         dram_base,
  input  logic               dram_rw,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic               dram_we
);

  localparam logic [26:0] WR_LIMIT = 27'(1) << DRAM_AW;

  logic [26:0] span;
  logic        both_dram;
  logic        below_limit;

  assign span        = f_dram_span(addr[31:24], dram_base, addr[23:0]);
  assign dram_addr   = span[DRAM_AW-1:0];
  assign both_dram   = (hi_src == SRC_DRAM) && (lo_src == SRC_DRAM);
  assign below_limit = span < WR_LIMIT;
  assign dram_we     = wr_req && both_dram && dram_rw && below_limit;

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import mmd_pkg::*;
#(
  parameter logic [11:0] CTRL_PAGE    = 12'hB78,
  parameter logic [7:0]  EN_OFS       = 8'h0C,
  parameter logic [7:0]  MODE_OFS     = 8'h00,
  parameter logic [7:0]  UNLOCK_KEY   = 8'h0A,
  parameter int unsigned BIOS_BYTES   = 32'h0004_0000,
  parameter int unsigned CART_BYTES   = 32'h00C0_0000,
  parameter int unsigned CFLASH_BYTES = 32'h0004_0000,
  parameter int          DRAM_AW      = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [31:0]        acc_addr,
  input  logic [31:0]        acc_wdata,
  output logic [2:0]         sel_hi,
  output logic [2:0]         sel_lo,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic               dram_we,
  output logic [31:0]        open_data,
  output logic [2:0]         mode_q,
  output logic               regs_en_q
);

  // Named internal events, also observed by the checker.
  logic       wr_req;
  logic       ctrl_page_hit;
  logic       en_wr_hit;
  logic       mode_wr_hit;
  src_e       hi_src, lo_src;
  logic [7:0] dram_base;
  logic       dram_rw;

  assign wr_req        = acc_valid && acc_write;
  assign ctrl_page_hit = acc_addr[31:20] == CTRL_PAGE;
  assign en_wr_hit     = wr_req && ctrl_page_hit && (acc_addr[7:0] == EN_OFS);
  assign mode_wr_hit   = wr_req && ctrl_page_hit && (acc_addr[7:0] == MODE_OFS);

  mmd_ctrl_regs #(.UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr_hit  (en_wr_hit),
    .mode_wr_hit(mode_wr_hit),
    .wbyte      (acc_wdata[7:0]),
    .regs_en_q  (regs_en_q),
    .mode_q     (mode_q)
  );

  mmd_region_decode #(
    .BIOS_BYTES  (BIOS_BYTES),
    .CART_BYTES  (CART_BYTES),
    .CFLASH_BYTES(CFLASH_BYTES),
    .IO_NIBBLE   (CTRL_PAGE[3:0])
  ) u_dec (
    .addr     (acc_addr),
    .mode     (mode_q),
    .hi_src   (hi_src),
    .lo_src   (lo_src),
    .dram_base(dram_base),
    .dram_rw  (dram_rw)
  );

  mmd_dram_gate #(.DRAM_AW(DRAM_AW)) u_gate (
    .addr     (acc_addr),
    .wr_req   (wr_req),
    .hi_src   (hi_src),
    .lo_src   (lo_src),
    .dram_base(dram_base),
    .dram_rw  (dram_rw),
    .dram_addr(dram_addr),
    .dram_we  (dram_we)
  );

  assign sel_hi    = hi_src;
  assign sel_lo    = lo_src;
  assign open_data = f_open_word(acc_addr);

endmodule

// File: rtl/mmd_checker.sv
module mmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [31:0] acc_addr,
  input logic [31:0] acc_wdata,
  input logic [2:0]  sel_hi,
  input logic [2:0]  sel_lo,
  input logic        dram_we,
  input logic [2:0]  mode_q,
  input logic        regs_en_q,
  input logic        en_wr_hit,
  input logic        mode_wr_hit
);

  // R2: correct key unlocks on the next cycle.
  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_hit && acc_wdata[7:0] == 8'h0A) |=> regs_en_q);

  // R2: any other key locks on the next cycle.
  p_relock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_hit && acc_wdata[7:0] != 8'h0A) |=> !regs_en_q);

  // R3: mode only moves on an unlocked mode write.
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr_hit && regs_en_q) |=> $stable(mode_q));

  // R8: control page is I/O in every mode.
  p_io_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[31:20] == 12'hB78) |-> (sel_hi == 3'd5 && sel_lo == 3'd5));

  // R8: top bytes above the map are open bus.
  p_high_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[31:24] > 8'hB7) |-> (sel_hi == 3'd6 && sel_lo == 3'd6));

  // R12: a DRAM write needs a valid write with both halves on DRAM.
  p_we_dram_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dram_we |-> (acc_valid && acc_write && sel_hi == 3'd3 && sel_lo == 3'd3));

  // R12: read-only modes never write.
  p_we_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dram_we |-> (mode_q < 3'd4));

endmodule

bind memmap_decoder mmd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_addr   (acc_addr),
  .acc_wdata  (acc_wdata),
  .sel_hi     (sel_hi),
  .sel_lo     (sel_lo),
  .dram_we    (dram_we),
  .mode_q     (mode_q),
  .regs_en_q  (regs_en_q),
  .en_wr_hit  (en_wr_hit),
  .mode_wr_hit(mode_wr_hit)
);

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic [31:0] acc_wdata = 32'h0;
  logic [2:0]  sel_hi, sel_lo;
  logic [24:0] dram_addr;
  logic        dram_we;
  logic [31:0] open_data;
  logic [2:0]  mode_q;
  logic        regs_en_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memmap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .dram_addr(dram_addr), .dram_we(dram_we), .open_data(open_data),
    .mode_q(mode_q), .regs_en_q(regs_en_q)
  );

  // Source codes from R4.
  localparam logic [2:0] BI = 3'd0, EX = 3'd1, CA = 3'd2, DR = 3'd3,
                         CF = 3'd4, IO = 3'd5, OP = 3'd6;

  // {mode, address, expected high source, expected low source}
  localparam int NV = 22;
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 32'hB000_0100, BI, BI},  // R4
    {3'd0, 32'hB100_0000, EX, EX},  // R4
    {3'd1, 32'hB200_0010, CA, CA},  // R4
    {3'd1, 32'hB400_0000, DR, DR},  // R4
    {3'd0, 32'hB700_0020, CF, CF},  // R4
    {3'd2, 32'hB000_0000, EX, EX},  // R5
    {3'd3, 32'hB100_0000, CA, CA},  // R5
    {3'd2, 32'hB600_0004, EX, BI},  // R5
    {3'd3, 32'hB700_0008, EX, CF},  // R5
    {3'd4, 32'hB200_0000, DR, DR},  // R6
    {3'd4, 32'hB400_0000, EX, EX},  // R6
    {3'd4, 32'hB500_0000, CA, CA},  // R6
    {3'd5, 32'hB500_0000, DR, DR},  // R7
    {3'd7, 32'hB600_0000, BI, BI},  // R7
    {3'd6, 32'hB780_0080, IO, IO},  // R8
    {3'd0, 32'hB800_0000, OP, OP},  // R8
    {3'd0, 32'hA000_0000, OP, OP},  // R8
    {3'd0, 32'hB050_0000, OP, OP},  // R9 BIOS past end
    {3'd2, 32'hB6F0_0000, EX, OP},  // R9 split, low half past end
    {3'd1, 32'hB2C0_0000, OP, OP},  // R9 cart exactly at size
    {3'd1, 32'hB2BF_FFFC, CA, CA},  // R9 last cart word
    {3'd0, 32'hB704_0000, OP, OP}   // R9 code flash past end
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  // Drive a combinational probe; outputs are sampled 2 ns later.
  task automatic probe(logic [31:0] a, logic w, logic v);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = 32'h0;
    #2;
  endtask

  task automatic set_mode(logic [2:0] m);
    wr(32'hB780_0000, {29'd0, m});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    probe(32'hB100_0000, 1'b0, 1'b1);
    chk("R1 mode", {29'd0, mode_q}, 32'd0);
    chk("R1 enable", {31'd0, regs_en_q}, 32'd0);
    chk("R1 mode0 map", {29'd0, sel_hi}, {29'd0, EX});
    // R3 mode write while locked is ignored
    set_mode(3'd2);
    probe(32'hB100_0000, 1'b0, 1'b1);
    chk("R3 locked mode", {29'd0, mode_q}, 32'd0);
    // R2 unlock with upper bits set
    wr(32'hB780_000C, 32'hFFFF_FF0A);
    probe(32'hB100_0000, 1'b0, 1'b0);
    chk("R2 unlock", {31'd0, regs_en_q}, 32'd1);
    set_mode(3'd2);
    probe(32'hB100_0000, 1'b0, 1'b0);
    chk("R3 unlocked mode", {29'd0, mode_q}, 32'd2);
    // R2 wrong key relocks; R3 then ignores a mode write
    wr(32'hB780_000C, 32'h0000_000B);
    probe(32'hB100_0000, 1'b0, 1'b0);
    chk("R2 relock", {31'd0, regs_en_q}, 32'd0);
    set_mode(3'd5);
    probe(32'hB100_0000, 1'b0, 1'b0);
    chk("R3 relocked mode", {29'd0, mode_q}, 32'd2);
    wr(32'hB780_000C, 32'h0000_000A);

    // Table walk: R4..R9
    for (int i = 0; i < NV; i++) begin
      set_mode(VEC[i][40:38]);
      probe(VEC[i][37:6], 1'b0, 1'b1);
      chk($sformatf("R4-map vec%0d hi", i), {29'd0, sel_hi}, {29'd0, VEC[i][5:3]});
      chk($sformatf("R4-map vec%0d lo", i), {29'd0, sel_lo}, {29'd0, VEC[i][2:0]});
    end

    // R10 open-bus word
    probe(32'hB900_1234, 1'b0, 1'b1);
    chk("R10 open word", open_data, 32'h1234_1234);
    probe(32'hA000_BEE8, 1'b0, 1'b1);
    chk("R10 open word 2", open_data, 32'hBEE8_BEE8);

    // R11 mirroring
    set_mode(3'd4);
    probe(32'hB200_0040, 1'b0, 1'b1);
    chk("R11 mode4 mirror", {7'd0, dram_addr}, 32'h40);
    probe(32'hB100_0100, 1'b0, 1'b1);
    chk("R11 mode4 second bank", {7'd0, dram_addr}, 32'h0100_0100);
    // R12 mode 4 read-only
    probe(32'hB000_0000, 1'b1, 1'b1);
    chk("R12 mode4 no write", {31'd0, dram_we}, 32'd0);

    set_mode(3'd0);
    probe(32'hB500_0010, 1'b0, 1'b1);
    chk("R11 mode0 wrap", {7'd0, dram_addr}, 32'h10);
    probe(32'hB300_0000, 1'b1, 1'b1);
    chk("R12 mode0 write low", {31'd0, dram_we}, 32'd1);
    probe(32'hB500_0000, 1'b1, 1'b1);
    chk("R12 beyond 32MB", {31'd0, dram_we}, 32'd0);
    probe(32'hB300_0000, 1'b0, 1'b1);
    chk("R12 read no we", {31'd0, dram_we}, 32'd0);
    probe(32'hB300_0000, 1'b1, 1'b0);
    chk("R12 idle no we", {31'd0, dram_we}, 32'd0);
    set_mode(3'd2);
    probe(32'hB300_0000, 1'b1, 1'b1);
    chk("R12 mode2 write", {31'd0, dram_we}, 32'd1);
    chk("R11 mode2 offset", {7'd0, dram_addr}, 32'h0100_0000);
    set_mode(3'd6);
    probe(32'hB000_0000, 1'b1, 1'b1);
    chk("R12 mode6 no write", {31'd0, dram_we}, 32'd0);

    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    finish_run();
  end

endmodule